// File: doc/BRIEF.md
# Page Table Walker

This block resolves translation misses in hardware for a single-level linear page table. A requester that failed to find a translation presents the virtual page number, the kind of access (read, write or execute) and the address-space identifier. The walker derives the entry's byte address from a programmable table base and fetches that entry over a request/response memory port. It then judges the entry.

A usable entry is written into the translation buffer through a one-cycle fill port, and the requester is then told to retry. An entry marked not present produces a segmentation fault. An entry that is present but forbids the requested access produces a protection fault. A fault, with the page number that caused it, stays posted until it is acknowledged. Only one walk is in flight at a time. The table base is written through a small configuration port.

Top module: `pgwalk_top`

## Requirements
- R1: `miss_ready` is high only while the walker is idle. On a clock edge with `miss_valid` and `miss_ready` high, the page number, access code and identifier are captured. From the next cycle `busy` is high and `miss_ready` is low until the walk ends, and a request presented meanwhile is ignored.
- R2: The entry address is the table base plus the page number times `PTE_BYTES` (default 4). It is driven on `mem_req_addr` with `mem_req_valid` in the cycle after acceptance and held unchanged until a cycle with `mem_req_ready` high.
- R3: After the request handshake, `mem_rsp_ready` is high and the walker waits any number of cycles for `mem_rsp_valid`. No fill, fault or retry happens before the response.
- R4: Entry layout: bit 0 = present, bit 1 = read allowed, bit 2 = write allowed, bit 3 = execute allowed, and bits above 3 = frame number. An entry with bit 0 clear raises `fault_valid` with `fault_code` 1, whatever its permission bits are, and never fills.
- R5: Access codes are 0 = read, 1 = write, 2 = execute, 3 = reserved. A present entry whose bit for the access is clear raises `fault_valid` with `fault_code` 2 and does not fill. Code 3 is never permitted.
- R6: A present and permitted entry gives `fill_valid` for one cycle, in the second cycle after the response handshake. The fill carries the page number, the frame number, the permissions {X,W,R} = entry bits 3..1, and the identifier. `retry` pulses in the next cycle, and then the walker is idle.
- R7: `fault_valid`, `fault_code` and `fault_vpn` (the walked page number) hold steady until a cycle with `fault_ack` high. The walker is idle in the cycle after the acknowledge, and no retry is given for a faulted walk.
- R8: A configuration write updates the base at the clock edge. A walk accepted on the same edge uses the previous base, and a write during a walk does not change that walk's address.
- R9: Under synchronous reset the walker is idle, every valid/pulse output is low and the base equals `BASE_RST` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table base write strobe |
| cfg_base | input | ADDR_W | New table base |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker can accept a miss |
| miss_vpn | input | VPN_W | Missing virtual page number |
| miss_acc | input | 2 | Access code |
| miss_asid | input | ASID_W | Address-space identifier |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Entry byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker awaits read data |
| mem_rsp_data | input | DATA_W | Page table entry |
| fill_valid | output | 1 | Write translation into buffer |
| fill_vpn | output | VPN_W | Page number to fill |
| fill_pfn | output | DATA_W-4 | Frame number to fill |
| fill_perm | output | 3 | Permissions {X,W,R} |
| fill_asid | output | ASID_W | Identifier to fill |
| retry | output | 1 | One-cycle retry pulse |
| fault_valid | output | 1 | Fault posted |
| fault_code | output | 2 | 1 segmentation, 2 protection |
| fault_vpn | output | VPN_W | Faulting page number |
| fault_ack | input | 1 | Clears a posted fault |

## Verification
A base register write and the acceptance of a new miss can land on the same clock edge. The bench provokes this by raising `cfg_we` with a new base in the same cycle as `miss_valid` and then comparing `mem_req_addr` against the address built from the older base. It also writes the base while a request is stalled by a low `mem_req_ready`, and checks that the pending address stays fixed. The walk that follows is then checked against the newly written base, which shows that the write did take effect.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PROT = 2'd2
  } flt_e;

  // one-hot state bit positions
  localparam int ST_N    = 7;
  localparam int S_IDLE  = 0;
  localparam int S_REQ   = 1;
  localparam int S_WAIT  = 2;
  localparam int S_CHECK = 3;
  localparam int S_FILL  = 4;
  localparam int S_DONE  = 5;
  localparam int S_FAULT = 6;

  // entry flag positions
  localparam int PTE_V     = 0;
  localparam int PTE_R     = 1;
  localparam int PTE_W     = 2;
  localparam int PTE_X     = 3;
  localparam int FLAG_W    = 4;
  localparam int PERM_W    = 3;

endpackage

// File: rtl/pgwalk_base.sv
module pgwalk_base #(
  parameter int ADDR_W    = 32,
  parameter int VPN_W     = 20,
  parameter int PTE_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] pte_addr
);
  localparam int SHIFT  = $clog2(PTE_BYTES);
  localparam bit IS_POW2 = ((1 << SHIFT) == PTE_BYTES);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (rst)         base_q <= BASE_RST;
    else if (cfg_we) base_q <= cfg_base;
  end

  generate
    if (IS_POW2) begin : g_shift
      assign offset = ADDR_W'(vpn) << SHIFT;
    end else begin : g_mul
      assign offset = ADDR_W'(vpn) * ADDR_W'(PTE_BYTES);
    end
  endgenerate

  assign pte_addr = base_q + offset;

endmodule

// File: rtl/pgwalk_pte_chk.sv
module pgwalk_pte_chk
  import pgwalk_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        acc,
  output logic              present,
  output logic              allowed,
  output logic [PERM_W-1:0] perm
);
  assign present = flags[PTE_V];
  assign perm    = {flags[PTE_X], flags[PTE_W], flags[PTE_R]};

  always_comb begin
    case (acc)
      ACC_RD:  allowed = flags[PTE_R];
      ACC_WR:  allowed = flags[PTE_W];
      ACC_EX:  allowed = flags[PTE_X];
      default: allowed = 1'b0;
    endcase
  end

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            miss_fire,
  input  logic            req_ready,
  input  logic            rsp_valid,
  input  logic            present,
  input  logic            allowed,
  input  logic            fault_ack,
  output logic [ST_N-1:0] st
);
  logic [ST_N-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (st[S_IDLE])  nxt[miss_fire ? S_REQ  : S_IDLE]  = 1'b1;
    if (st[S_REQ])   nxt[req_ready ? S_WAIT : S_REQ]   = 1'b1;
    if (st[S_WAIT])  nxt[rsp_valid ? S_CHECK : S_WAIT] = 1'b1;
    if (st[S_CHECK]) nxt[(present && allowed) ? S_FILL : S_FAULT] = 1'b1;
    if (st[S_FILL])  nxt[S_DONE] = 1'b1;
    if (st[S_DONE])  nxt[S_IDLE] = 1'b1;
    if (st[S_FAULT]) nxt[fault_ack ? S_IDLE : S_FAULT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_N'(1) << S_IDLE;
    else     st <= nxt;
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter int PTE_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_RST = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_base,
  input  logic                     miss_valid,
  output logic                     miss_ready,
  input  logic [VPN_W-1:0]         miss_vpn,
  input  logic [1:0]               miss_acc,
  input  logic [ASID_W-1:0]        miss_asid,
  output logic                     busy,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid,
  output logic                     mem_rsp_ready,
  input  logic [DATA_W-1:0]        mem_rsp_data,
  output logic                     fill_valid,
  output logic [VPN_W-1:0]         fill_vpn,
  output logic [DATA_W-FLAG_W-1:0] fill_pfn,
  output logic [PERM_W-1:0]        fill_perm,
  output logic [ASID_W-1:0]        fill_asid,
  output logic                     retry,
  output logic                     fault_valid,
  output logic [1:0]               fault_code,
  output logic [VPN_W-1:0]         fault_vpn,
  input  logic                     fault_ack
);
  localparam int PFN_W = DATA_W - FLAG_W;

  logic [ST_N-1:0]   st;
  logic              miss_fire;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [1:0]        acc_q;
  logic [ASID_W-1:0] asid_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [FLAG_W-1:0] flg_q;
  logic [1:0]        code_q;
  logic              present;
  logic              allowed;
  logic [PERM_W-1:0] perm;

  assign miss_fire = miss_valid && st[S_IDLE];

  pgwalk_base #(
    .ADDR_W(ADDR_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES), .BASE_RST(BASE_RST)
  ) u_base (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .vpn(miss_vpn), .pte_addr(addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      vpn_q  <= '0;
      acc_q  <= '0;
      asid_q <= '0;
      pfn_q  <= '0;
      flg_q  <= '0;
      code_q <= FLT_NONE;
    end else begin
      if (miss_fire) begin
        addr_q <= addr_nxt;
        vpn_q  <= miss_vpn;
        acc_q  <= miss_acc;
        asid_q <= miss_asid;
      end
      if (st[S_WAIT] && mem_rsp_valid) begin
        pfn_q <= mem_rsp_data[DATA_W-1:FLAG_W];
        flg_q <= mem_rsp_data[FLAG_W-1:0];
      end
      if (st[S_CHECK]) begin
        if (!present)      code_q <= FLT_SEG;
        else if (!allowed) code_q <= FLT_PROT;
        else               code_q <= FLT_NONE;
      end
    end
  end

  pgwalk_pte_chk u_chk (
    .flags(flg_q), .acc(acc_q),
    .present(present), .allowed(allowed), .perm(perm)
  );

  pgwalk_fsm u_fsm (
    .clk(clk), .rst(rst), .miss_fire(miss_fire),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
    .present(present), .allowed(allowed), .fault_ack(fault_ack),
    .st(st)
  );

  assign miss_ready    = st[S_IDLE];
  assign busy          = ~st[S_IDLE];
  assign mem_req_valid = st[S_REQ];
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = st[S_WAIT];
  assign fill_valid    = st[S_FILL];
  assign fill_vpn      = vpn_q;
  assign fill_pfn      = pfn_q;
  assign fill_perm     = perm;
  assign fill_asid     = asid_q;
  assign retry         = st[S_DONE];
  assign fault_valid   = st[S_FAULT];
  assign fault_code    = code_q;
  assign fault_vpn     = vpn_q;

endmodule

// File: rtl/pgwalk_sva.sv
module pgwalk_sva #(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              fill_valid,
  input logic              retry,
  input logic              fault_valid,
  input logic [1:0]        fault_code,
  input logic [VPN_W-1:0]  fault_vpn,
  input logic              fault_ack
);
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(miss_valid && miss_ready)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2

  AST_RSP_WAIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_ready |-> busy && !mem_req_valid && !fill_valid && !fault_valid); // R3

  AST_FAULT_CODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_code == 2'd1 || fault_code == 2'd2)); // R4

  AST_FILL_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $past(mem_rsp_valid && mem_rsp_ready, 2)); // R6

  AST_FILL_THEN_RETRY: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> retry && !fill_valid); // R6

  AST_IDLE_AFTER_RETRY: assert property (@(posedge clk) disable iff (rst)
    retry |=> !busy); // R6

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    fault_valid && !fault_ack |=> fault_valid && $stable(fault_code) && $stable(fault_vpn)); // R7

  AST_NO_RETRY_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> !retry && !fill_valid); // R7

endmodule

bind pgwalk_top pgwalk_sva #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) u_sva (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready), .fill_valid(fill_valid), .retry(retry),
  .fault_valid(fault_valid), .fault_code(fault_code), .fault_vpn(fault_vpn),
  .fault_ack(fault_ack)
);

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [19:0] miss_vpn = '0;
  logic [1:0]  miss_acc = '0;
  logic [7:0]  miss_asid = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [27:0] fill_pfn;
  logic [2:0]  fill_perm;
  logic [7:0]  fill_asid;
  logic        retry;
  logic        fault_valid;
  logic [1:0]  fault_code;
  logic [19:0] fault_vpn;
  logic        fault_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn),
    .miss_acc(miss_acc), .miss_asid(miss_asid), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .fill_asid(fill_asid), .retry(retry),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_vpn(fault_vpn),
    .fault_ack(fault_ack)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [1:0]  acc;
    logic [7:0]  asid;
    logic [31:0] pte;
    logic [3:0]  lat;
    logic [1:0]  stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{20'h00001, 2'd0, 8'h11, 32'h0123_4563, 4'd0, 2'd0},
    '{20'h00ABC, 2'd1, 8'h22, 32'h0AAA_AAA5, 4'd3, 2'd2},
    '{20'hFFFFF, 2'd2, 8'h33, 32'h0077_7779, 4'd1, 2'd1},
    '{20'h00010, 2'd0, 8'h44, 32'h1234_500E, 4'd2, 2'd0},
    '{20'h00020, 2'd1, 8'h55, 32'h5555_555B, 4'd0, 2'd1},
    '{20'h00030, 2'd2, 8'h66, 32'h0000_0017, 4'd4, 2'd0},
    '{20'h00040, 2'd3, 8'h77, 32'hFFFF_FFFF, 4'd1, 2'd0},
    '{20'h00050, 2'd0, 8'h88, 32'h0000_0000, 4'd7, 2'd3},
    '{20'h00060, 2'd1, 8'h99, 32'h0000_0002, 4'd2, 2'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one complete walk; called at a negedge with the walker idle
  task automatic do_walk(input vec_t v, input logic [31:0] base_exp,
                         input bit cfg_at_acc, input bit cfg_mid,
                         input logic [31:0] cfg_val, input bit poke);
    logic [31:0] exp_addr;
    bit ok_v;
    bit ok_p;
    exp_addr = base_exp + {10'd0, v.vpn, 2'b00};
    ok_v = v.pte[0];
    ok_p = (v.acc == 2'd3) ? 1'b0 : v.pte[1 + v.acc];

    chk("R1 ready when idle", miss_ready, 1);
    miss_valid = 1'b1; miss_vpn = v.vpn; miss_acc = v.acc; miss_asid = v.asid;
    if (cfg_at_acc) begin cfg_we = 1'b1; cfg_base = cfg_val; end
    @(negedge clk);
    miss_valid = 1'b0; cfg_we = 1'b0;
    chk("R1 busy after accept", busy, 1);
    chk("R1 not ready while busy", miss_ready, 0);
    chk("R2 request valid", mem_req_valid, 1);
    chk("R2 R8 entry address", mem_req_addr, exp_addr);
    if (cfg_mid) begin cfg_we = 1'b1; cfg_base = cfg_val; end
    if (poke) begin miss_valid = 1'b1; miss_vpn = ~v.vpn; end
    for (int i = 0; i < v.stall; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R2 request held", mem_req_valid, 1);
      chk("R2 R8 address held", mem_req_addr, exp_addr);
      if (poke) chk("R1 busy request ignored", miss_ready, 0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R3 awaiting data", mem_rsp_ready, 1);
    chk("R3 request dropped", mem_req_valid, 0);
    for (int i = 0; i < v.lat; i++) begin
      @(negedge clk);
      chk("R3 no early outcome", fill_valid | fault_valid | retry, 0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = v.pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    miss_valid = 1'b0;
    chk("R6 no fill in check cycle", fill_valid | fault_valid, 0);
    @(negedge clk);
    if (!ok_v) begin
      chk("R4 segmentation fault", fault_valid, 1);
      chk("R4 fault code", fault_code, 1);
      chk("R4 no fill", fill_valid, 0);
    end else if (!ok_p) begin
      chk("R5 protection fault", fault_valid, 1);
      chk("R5 fault code", fault_code, 2);
      chk("R5 no fill", fill_valid, 0);
    end else begin
      chk("R6 fill valid", fill_valid, 1);
      chk("R6 fill vpn", fill_vpn, v.vpn);
      chk("R6 fill pfn", fill_pfn, v.pte[31:4]);
      chk("R6 fill perm", fill_perm, v.pte[3:1]);
      chk("R6 fill asid", fill_asid, v.asid);
      chk("R6 no fault", fault_valid, 0);
    end
    if (ok_v && ok_p) begin
      @(negedge clk);
      chk("R6 retry pulse", retry, 1);
      chk("R6 fill one cycle", fill_valid, 0);
      @(negedge clk);
      chk("R6 retry ends", retry, 0);
      chk("R6 idle after retry", busy, 0);
    end else begin
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        chk("R7 fault held", fault_valid, 1);
        chk("R7 fault code held", fault_code, ok_v ? 2 : 1);
        chk("R7 fault vpn", fault_vpn, v.vpn);
        chk("R7 no retry", retry, 0);
      end
      fault_ack = 1'b1;
      @(negedge clk);
      fault_ack = 1'b0;
      chk("R7 fault cleared", fault_valid, 0);
      chk("R7 idle after ack", busy, 0);
    end
    chk("R1 no extra walk", mem_req_valid, 0);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state, checked while reset is still applied
    chk("R9 reset busy", busy, 0);
    chk("R9 reset ready", miss_ready, 1);
    chk("R9 reset outputs", {mem_req_valid, mem_rsp_ready, fill_valid, retry, fault_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R9: base after reset is zero
    do_walk('{20'h00007, 2'd0, 8'h01, 32'h0000_0103, 4'd1, 2'd0}, 32'h0, 0, 0, 0, 0);

    // program the base
    cfg_we = 1'b1; cfg_base = 32'h0010_0000;
    @(negedge clk);
    cfg_we = 1'b0;

    for (int k = 0; k < NV; k++) begin
      do_walk(VEC[k], 32'h0010_0000, 0, 0, 0, 0);
      @(negedge clk);
    end

    // R8: write on the same edge as acceptance, old base used
    do_walk('{20'h00100, 2'd0, 8'hA1, 32'h0BEE_F003, 4'd0, 2'd0},
            32'h0010_0000, 1, 0, 32'h0020_0000, 0);
    // R8: the write above took effect; a write during this walk does not disturb it
    do_walk('{20'h00200, 2'd1, 8'hA2, 32'h0CAF_E005, 4'd1, 2'd2},
            32'h0020_0000, 0, 1, 32'h0030_0000, 0);
    // R1: a request presented while busy is ignored
    do_walk('{20'h00300, 2'd2, 8'hA3, 32'h0D00_D009, 4'd2, 2'd2},
            32'h0030_0000, 0, 0, 0, 1);
    // R1 with a fault: busy request ignored until acknowledge
    do_walk('{20'h00400, 2'd2, 8'hA4, 32'h0D00_D003, 4'd0, 2'd1},
            32'h0030_0000, 0, 0, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule